// File: doc/BRIEF.md
# Host Controller Run/Stop/Reset Sequencer

This block owns the top-level operating state of a USB host controller. Software drives a run request bit and a self-clearing soft-reset bit through a single write strobe. The block answers with a halted status, a schedule-enable output to the transaction engine, and a soft-reset request to the controller's internal pipelines, timers and state machines. It waits for a reset-complete acknowledge before it leaves the reset state.

A stop is graceful. Schedule execution ends at once, but the halted status appears only after the engine reports that no transaction is in flight. A soft reset is abortive. It signals the engine to drop any transaction in progress and holds the reset bit set until the internal reset is acknowledged; software cannot clear it early. A soft reset never drives a reset onto downstream ports. Ordering violations by software (a run request while the controller is not halted, or a reset request while it is not halted) each raise a one-cycle error pulse.

Top module: `hc_runctl`

## Requirements
- R1: After the hardware reset `rst_n`, `halted`=1, `run_stat`=0, `rst_stat`=0, `sched_en`=0, `int_rst_req`=0, `txn_abort`=0 and both error pulses are 0.
- R2: A write (`cmd_wr`=1) with `cmd_rst`=0 and `cmd_run`=1 while halted sets `run_stat`=1, `sched_en`=1 and `halted`=0 from the next cycle. These stay set for as long as no further write changes them.
- R3: A write with `cmd_rst`=0 and `cmd_run`=0 while running clears `run_stat` and `sched_en` on the next cycle. `halted` stays 0 while `txn_busy` is 1. The same write while halted changes nothing.
- R4: While stopping, `halted` rises on the cycle after the first clock edge at which `txn_busy` is 0.
- R5: A write with `cmd_rst`=0 and `cmd_run`=1 while running or stopping leaves the state unchanged. `err_run_active` is 1 for exactly the following cycle.
- R6: A write with `cmd_rst`=1 enters the reset state on the next cycle, taking priority over `cmd_run` in the same write. In the reset state `rst_stat`=1, `int_rst_req`=1, `run_stat`=0, `sched_en`=0 and `halted`=0, and `txn_abort` equals `txn_busy`.
- R7: While in the reset state, writes have no effect. Writing `cmd_rst`=0 does not clear `rst_stat`, and writing `cmd_run`=1 does not set `run_stat`.
- R8: In the reset state, a clock edge with `reset_done`=1 leads on the next cycle to `halted`=1, `rst_stat`=0, `run_stat`=0 and `int_rst_req`=0.
- R9: A reset request made while running or stopping is still carried out, and `err_rst_active` is 1 for exactly the following cycle. A reset request made while halted leaves `err_rst_active` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_run | input | 1 | Written value of the run request bit |
| cmd_rst | input | 1 | Written value of the soft-reset bit |
| txn_busy | input | 1 | Transaction engine has a transaction in flight |
| reset_done | input | 1 | Internal soft reset has completed |
| run_stat | output | 1 | Readback of the run request bit |
| rst_stat | output | 1 | Readback of the soft-reset bit |
| halted | output | 1 | Controller is fully stopped |
| sched_en | output | 1 | Transaction engine may execute the schedule |
| txn_abort | output | 1 | Drop the transaction in flight now |
| int_rst_req | output | 1 | Request to reset pipelines, timers and state machines |
| err_run_active | output | 1 | Pulse: run requested while not halted |
| err_rst_active | output | 1 | Pulse: soft reset requested while not halted |

## Verification
The bench stops with a transaction held busy for several cycles. A design that reports halted at the moment of the stop write, instead of after the engine goes idle, is caught there. It writes zero to the reset bit and one to the run bit during a soft reset; a design that lets software cancel the reset or start the schedule early would show a cleared reset readback or a set run readback. It issues run requests in both the running and the stopping states, and a single write with both bits set. These catch a decoder that restarts a stopping controller, forgets the error pulse, or lets the run bit win over reset. Resets are issued from the halted state and from a busy running state, so a misplaced error flag or a missing abort is visible.

// File: rtl/hc_runctl_pkg.sv
package hc_runctl_pkg;

    typedef enum logic [1:0] {
        ST_HALTED    = 2'd0,
        ST_RUNNING   = 2'd1,
        ST_STOPPING  = 2'd2,
        ST_RESETTING = 2'd3
    } hc_state_e;

    // Classified software write
    typedef struct packed {
        logic do_reset;
        logic do_run;
        logic do_stop;
        logic bad_run;
        logic bad_reset;
    } hc_req_s;

    // Registered control state
    typedef struct packed {
        hc_state_e state;
        logic      run_bit;
        logic      rst_bit;
        logic      err_run;
        logic      err_rst;
    } hc_ctl_s;

    localparam hc_ctl_s HC_CTL_RESET = '{
        state:   ST_HALTED,
        run_bit: 1'b0,
        rst_bit: 1'b0,
        err_run: 1'b0,
        err_rst: 1'b0
    };

endpackage

// File: rtl/hc_cmd_decode.sv
module hc_cmd_decode
    import hc_runctl_pkg::*;
(
    input  hc_state_e state_i,
    input  logic      wr_i,
    input  logic      run_i,
    input  logic      rst_i,
    output hc_req_s   req_o
);

    logic in_reset;
    logic is_halted;
    logic is_active;
    logic run_write;

    always_comb begin
        in_reset  = (state_i == ST_RESETTING);
        is_halted = (state_i == ST_HALTED);
        is_active = (state_i == ST_RUNNING) || (state_i == ST_STOPPING);
        // a write carrying the reset bit is never treated as a run/stop write
        run_write = wr_i && !rst_i && !in_reset;

        req_o.do_reset  = wr_i && rst_i && !in_reset;
        req_o.bad_reset = wr_i && rst_i && is_active;
        req_o.do_run    = run_write && run_i && is_halted;
        req_o.bad_run   = run_write && run_i && is_active;
        req_o.do_stop   = run_write && !run_i && (state_i == ST_RUNNING);
    end

endmodule

// File: rtl/hc_runctl_fsm.sv
module hc_runctl_fsm
    import hc_runctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  hc_req_s req_i,
    input  logic    txn_busy_i,
    input  logic    reset_done_i,
    output hc_ctl_s ctl_o
);

    hc_ctl_s ctl_d;
    hc_ctl_s ctl_q;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.err_run = req_i.bad_run;
        ctl_d.err_rst = req_i.bad_reset;

        if (req_i.do_reset) begin
            ctl_d.state   = ST_RESETTING;
            ctl_d.rst_bit = 1'b1;
            ctl_d.run_bit = 1'b0;
        end else begin
            unique case (ctl_q.state)
                ST_HALTED: begin
                    if (req_i.do_run) begin
                        ctl_d.state   = ST_RUNNING;
                        ctl_d.run_bit = 1'b1;
                    end
                end
                ST_RUNNING: begin
                    if (req_i.do_stop) begin
                        ctl_d.state   = ST_STOPPING;
                        ctl_d.run_bit = 1'b0;
                    end
                end
                ST_STOPPING: begin
                    if (!txn_busy_i) begin
                        ctl_d.state = ST_HALTED;
                    end
                end
                ST_RESETTING: begin
                    if (reset_done_i) begin
                        ctl_d.state   = ST_HALTED;
                        ctl_d.rst_bit = 1'b0;
                        ctl_d.run_bit = 1'b0;
                    end
                end
                default: ctl_d = HC_CTL_RESET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= HC_CTL_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl_o = ctl_q;

endmodule

// File: rtl/hc_status_out.sv
module hc_status_out
    import hc_runctl_pkg::*;
(
    input  hc_ctl_s ctl_i,
    input  logic    txn_busy_i,
    output logic    run_stat_o,
    output logic    rst_stat_o,
    output logic    halted_o,
    output logic    sched_en_o,
    output logic    txn_abort_o,
    output logic    int_rst_req_o,
    output logic    err_run_o,
    output logic    err_rst_o
);

    always_comb begin
        run_stat_o    = ctl_i.run_bit;
        rst_stat_o    = ctl_i.rst_bit;
        halted_o      = (ctl_i.state == ST_HALTED);
        sched_en_o    = (ctl_i.state == ST_RUNNING);
        int_rst_req_o = (ctl_i.state == ST_RESETTING);
        txn_abort_o   = (ctl_i.state == ST_RESETTING) && txn_busy_i;
        err_run_o     = ctl_i.err_run;
        err_rst_o     = ctl_i.err_rst;
    end

endmodule

// File: rtl/hc_runctl.sv
module hc_runctl
    import hc_runctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_run,
    input  logic cmd_rst,
    input  logic txn_busy,
    input  logic reset_done,
    output logic run_stat,
    output logic rst_stat,
    output logic halted,
    output logic sched_en,
    output logic txn_abort,
    output logic int_rst_req,
    output logic err_run_active,
    output logic err_rst_active
);

    hc_req_s req;
    hc_ctl_s ctl;

    hc_cmd_decode u_decode (
        .state_i (ctl.state),
        .wr_i    (cmd_wr),
        .run_i   (cmd_run),
        .rst_i   (cmd_rst),
        .req_o   (req)
    );

    hc_runctl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .txn_busy_i   (txn_busy),
        .reset_done_i (reset_done),
        .ctl_o        (ctl)
    );

    hc_status_out u_status (
        .ctl_i         (ctl),
        .txn_busy_i    (txn_busy),
        .run_stat_o    (run_stat),
        .rst_stat_o    (rst_stat),
        .halted_o      (halted),
        .sched_en_o    (sched_en),
        .txn_abort_o   (txn_abort),
        .int_rst_req_o (int_rst_req),
        .err_run_o     (err_run_active),
        .err_rst_o     (err_rst_active)
    );

endmodule

// File: rtl/hc_runctl_chk.sv
module hc_runctl_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_wr,
    input logic cmd_run,
    input logic cmd_rst,
    input logic txn_busy,
    input logic reset_done,
    input logic run_stat,
    input logic rst_stat,
    input logic halted,
    input logic sched_en,
    input logic txn_abort,
    input logic int_rst_req,
    input logic err_run_active,
    input logic err_rst_active
);

    AST_SCHED_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        sched_en |-> (run_stat && !halted)); // R2

    AST_STOP_WAITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sched_en && !halted && !int_rst_req && txn_busy) |=> !halted); // R3

    AST_ABORT_ONLY_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        txn_abort |-> (int_rst_req && !halted && !sched_en)); // R6

    AST_RESET_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rst_req && !reset_done) |=> (rst_stat && int_rst_req)); // R7

    AST_RESET_EXIT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rst_req && reset_done) |=> (halted && !rst_stat && !run_stat)); // R8

    AST_RUN_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        err_run_active |-> ($stable(sched_en) && $stable(halted))); // R5

    AST_RST_ERR_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        err_rst_active |-> int_rst_req); // R9

endmodule

bind hc_runctl hc_runctl_chk u_chk (.*);

// File: tb/hc_runctl_tb.sv
module hc_runctl_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_wr = 1'b0;
    logic cmd_run = 1'b0;
    logic cmd_rst = 1'b0;
    logic txn_busy = 1'b0;
    logic reset_done = 1'b0;
    logic run_stat, rst_stat, halted, sched_en, txn_abort, int_rst_req;
    logic err_run_active, err_rst_active;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hc_runctl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_wr         (cmd_wr),
        .cmd_run        (cmd_run),
        .cmd_rst        (cmd_rst),
        .txn_busy       (txn_busy),
        .reset_done     (reset_done),
        .run_stat       (run_stat),
        .rst_stat       (rst_stat),
        .halted         (halted),
        .sched_en       (sched_en),
        .txn_abort      (txn_abort),
        .int_rst_req    (int_rst_req),
        .err_run_active (err_run_active),
        .err_rst_active (err_rst_active)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // drive one write at a falling edge; returns at the falling edge after the capturing edge
    task automatic wr(input logic run, input logic rst);
        cmd_wr  = 1'b1;
        cmd_run = run;
        cmd_rst = rst;
        @(negedge clk);
        cmd_wr  = 1'b0;
        cmd_run = 1'b0;
        cmd_rst = 1'b0;
    endtask

    task automatic finish_reset();
        reset_done = 1'b1;
        tick();
        reset_done = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R1", "halted", halted, 1'b1);
        chk("R1", "run_stat", run_stat, 1'b0);
        chk("R1", "rst_stat", rst_stat, 1'b0);
        chk("R1", "sched_en", sched_en, 1'b0);
        chk("R1", "int_rst_req", int_rst_req, 1'b0);
        chk("R1", "txn_abort", txn_abort, 1'b0);
        chk("R1", "err_run", err_run_active, 1'b0);
        chk("R1", "err_rst", err_rst_active, 1'b0);
    endtask

    task automatic t_start();
        wr(1'b1, 1'b0);
        chk("R2", "run_stat", run_stat, 1'b1);
        chk("R2", "sched_en", sched_en, 1'b1);
        chk("R2", "halted", halted, 1'b0);
        chk("R2", "err_run", err_run_active, 1'b0);
        repeat (3) tick();
        chk("R2", "sched_en held", sched_en, 1'b1);
    endtask

    task automatic t_run_while_running();
        wr(1'b1, 1'b0);
        chk("R5", "err_run", err_run_active, 1'b1);
        chk("R5", "sched_en kept", sched_en, 1'b1);
        tick();
        chk("R5", "err_run one cycle", err_run_active, 1'b0);
    endtask

    task automatic t_stop_busy();
        txn_busy = 1'b1;
        wr(1'b0, 1'b0);
        chk("R3", "run_stat", run_stat, 1'b0);
        chk("R3", "sched_en", sched_en, 1'b0);
        chk("R3", "halted early", halted, 1'b0);
        repeat (3) tick();
        chk("R3", "halted while busy", halted, 1'b0);
        wr(1'b1, 1'b0);
        chk("R5", "err_run stopping", err_run_active, 1'b1);
        chk("R5", "sched_en stopping", sched_en, 1'b0);
        chk("R5", "run_stat stopping", run_stat, 1'b0);
        txn_busy = 1'b0;
        tick();
        chk("R4", "halted after idle", halted, 1'b1);
    endtask

    task automatic t_stop_idle();
        wr(1'b1, 1'b0);
        wr(1'b0, 1'b0);
        chk("R4", "not yet halted", halted, 1'b0);
        tick();
        chk("R4", "halted", halted, 1'b1);
        wr(1'b0, 1'b0);
        chk("R3", "stop write while halted", halted, 1'b1);
        chk("R3", "no error", err_run_active, 1'b0);
    endtask

    task automatic t_reset_from_halted();
        wr(1'b0, 1'b1);
        chk("R6", "rst_stat", rst_stat, 1'b1);
        chk("R6", "int_rst_req", int_rst_req, 1'b1);
        chk("R6", "halted", halted, 1'b0);
        chk("R9", "no err when halted", err_rst_active, 1'b0);
        wr(1'b0, 1'b0);
        chk("R7", "rst_stat after write 0", rst_stat, 1'b1);
        wr(1'b1, 1'b0);
        chk("R7", "run ignored", run_stat, 1'b0);
        chk("R7", "still in reset", int_rst_req, 1'b1);
        repeat (2) tick();
        chk("R7", "rst_stat held", rst_stat, 1'b1);
        finish_reset();
        chk("R8", "halted", halted, 1'b1);
        chk("R8", "rst_stat cleared", rst_stat, 1'b0);
        chk("R8", "int_rst_req", int_rst_req, 1'b0);
        chk("R8", "run_stat", run_stat, 1'b0);
    endtask

    task automatic t_reset_from_running();
        wr(1'b1, 1'b0);
        txn_busy = 1'b1;
        wr(1'b0, 1'b1);
        chk("R9", "err_rst", err_rst_active, 1'b1);
        chk("R6", "txn_abort", txn_abort, 1'b1);
        chk("R6", "sched_en", sched_en, 1'b0);
        chk("R6", "run_stat", run_stat, 1'b0);
        txn_busy = 1'b0;
        tick();
        chk("R9", "err_rst one cycle", err_rst_active, 1'b0);
        chk("R6", "abort follows busy", txn_abort, 1'b0);
        finish_reset();
        chk("R8", "halted after abort", halted, 1'b1);
    endtask

    task automatic t_reset_priority();
        wr(1'b1, 1'b1);
        chk("R6", "reset wins rst_stat", rst_stat, 1'b1);
        chk("R6", "reset wins run_stat", run_stat, 1'b0);
        chk("R6", "reset wins sched_en", sched_en, 1'b0);
        finish_reset();
        chk("R8", "halted", halted, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset_state();
        t_start();
        t_run_while_running();
        t_stop_busy();
        t_stop_idle();
        t_reset_from_halted();
        t_reset_from_running();
        t_reset_priority();
        finished = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule